// File: doc/BRIEF.md
# Temperature-Indexed Drift Compensation Cache

This block remembers how far a node's local oscillator was off frequency at each temperature it has seen. Temperature is quantized to whole degrees Celsius. Each degree in the range -16 °C to 63 °C has one table slot. A slot holds a valid flag and a signed error in units of 0.01 ppm. Whenever the node finishes a network resynchronization, it strobes the measured error in. The block files that error under the temperature present on that cycle.

An internal timer issues a lookup every programmable number of clock cycles. If the current temperature's slot is valid, the block reports a hit with the stored error, and the node may skip resynchronization. If the slot is empty, the block raises a resync request. It also runs a fixed-point quadratic drift model, fe(T) = B - A*(T - T0)^2, to supply an interim estimate. That estimate arrives a fixed time after the lookup result.

Temperature sensing, radio traffic and the synchronization protocol itself live outside this block.

Top module: `drift_cache`

## Requirements
- R1: After synchronous reset, every output is zero and every table slot is empty, so the first lookup at any temperature misses.
- R2: When `upd_i` is high and the temperature is in range, `upd_err_i` is stored in the slot numbered temp_i + 16 (slot 0 holds -16 °C and slot 79 holds 63 °C).
- R3: A lookup whose slot is valid yields, one cycle after the check is issued, `resp_valid_o`=1, `hit_o`=1, `resync_req_o`=0 and `cached_err_o` equal to the stored error. No `est_valid_o` pulse follows.
- R4: A lookup whose slot is empty yields `resp_valid_o`=1, `hit_o`=0, `resync_req_o`=1 and `cached_err_o`=0. `est_valid_o` then pulses for exactly one cycle, two cycles after `resp_valid_o`.
- R5: The estimate equals B - ((A*(T-T0)^2) >>> 8). A is `coef_a_i`, a signed coefficient in 1/256 of 0.01 ppm per °C². B is `coef_b_i` in 0.01 ppm. T0 defaults to 20. The shift rounds toward minus infinity. The temperature and both coefficients are those present when the check is issued.
- R6: An estimate outside the 16-bit signed range is clamped to 32767 or -32768.
- R7: A temperature below -16 or above 63 is never cached. An update at such a temperature is ignored, and a lookup there always misses.
- R8: A one-cycle `clr_i` pulse empties every slot. A write on the same cycle as a clear lands after the clear, so that slot stays valid.
- R9: A lookup on the same cycle as a write to the same temperature hits and returns the value being written.
- R10: With `period_i`=P>0, a check is issued every P cycles, the first one P cycles after P is loaded from zero. With P=0, no checks are issued.
- R11: A later write to an already valid slot replaces the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_i | input | 8 | Current temperature, signed whole °C |
| upd_i | input | 1 | Resynchronization result strobe |
| upd_err_i | input | 16 | Measured frequency error, signed, 0.01 ppm |
| clr_i | input | 1 | Empty the whole table |
| period_i | input | 32 | Check interval in clock cycles, 0 disables |
| coef_a_i | input | 16 | Model curvature A, signed, 8 fraction bits |
| coef_b_i | input | 16 | Model offset B, signed, 0.01 ppm |
| resp_valid_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Slot was valid, no resync needed |
| resync_req_o | output | 1 | Slot was empty, resync requested |
| cached_err_o | output | 16 | Stored error on a hit, else zero |
| est_valid_o | output | 1 | Model estimate valid |
| est_o | output | 16 | Model estimate, signed, 0.01 ppm |

## Verification
The bench probes both ends of the temperature range and one degree past each end. A design with an off-by-one bin mapping either loses the edge slots or aliases an out-of-range temperature onto a real slot. It issues a write and a lookup on the same cycle, where a missing bypass would report a stale miss. It also issues a clear together with a write, where the wrong precedence would leave that slot empty. The model is driven with a negative product so that a truncating shift shows up one count off, and with extreme coefficients that would wrap instead of clamping. The check interval is timed from a zero period, so a counter that is one cycle off, or one that keeps running at period zero, is caught.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int TEMP_W = 8;
  localparam int ERR_W  = 16;
  typedef logic signed [TEMP_W-1:0] temp_t;
  typedef logic signed [ERR_W-1:0]  err_t;
endpackage

// File: rtl/dc_bin_map.sv
module dc_bin_map
  import dc_pkg::*;
#(
  parameter int TMIN  = -16,
  parameter int NBINS = 80,
  parameter int IDX_W = 7
) (
  input  temp_t             temp,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range
);
  localparam int DW = TEMP_W + 1;
  localparam logic signed [DW-1:0] TMIN_D = DW'(TMIN);

  logic signed [DW-1:0] diff;

  always_comb begin
    diff     = $signed({temp[TEMP_W-1], temp}) - TMIN_D;
    in_range = (diff >= 0) && (int'(diff) < NBINS);
    idx      = in_range ? IDX_W'(diff) : '0;
  end
endmodule

// File: rtl/dc_table.sv
module dc_table
  import dc_pkg::*;
#(
  parameter int NBINS = 80,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             we,
  input  logic             re,
  input  logic             in_range,
  input  logic [IDX_W-1:0] idx,
  input  err_t             wdata,
  output logic             hit_q,
  output err_t             val_q
);
  err_t             mem [NBINS];
  logic [NBINS-1:0] vld;

  // data array: no reset, single write port, so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  // registered read with a bypass for a same-cycle write
  always_ff @(posedge clk) begin
    if (rst)     val_q <= '0;
    else if (re) val_q <= we ? wdata : mem[idx];
  end

  // valid flags kept in flops so a clear empties them in one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      if (clr) vld <= '0;
      if (we)  vld[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= re && in_range && (we || (!clr && vld[idx]));
  end
endmodule

// File: rtl/dc_quad.sv
module dc_quad
  import dc_pkg::*;
#(
  parameter int T0     = 20,
  parameter int A_FRAC = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  miss,
  input  temp_t temp,
  input  err_t  coef_a,
  input  err_t  coef_b,
  output logic  est_vld_q,
  output err_t  est_q
);
  localparam int D_W  = TEMP_W + 1;
  localparam int SQ_W = 2 * D_W;
  localparam int P_W  = ERR_W + SQ_W + 1;
  localparam int R_W  = P_W + 1;
  localparam logic signed [D_W-1:0] T0_D = D_W'(T0);

  // stage 1: offset from the model centre, coefficients captured
  logic                  s1_v;
  logic signed [D_W-1:0] s1_d;
  err_t                  s1_a, s1_b;
  // stage 2: square, gated by the table's miss result
  logic                  s2_v;
  logic [SQ_W-1:0]       s2_sq;
  err_t                  s2_a, s2_b;

  logic signed [P_W-1:0] a_ext, sq_ext, prod, shr;
  logic signed [R_W-1:0] diff;
  err_t                  sat;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_d <= '0; s1_a <= '0; s1_b <= '0;
      s2_v <= 1'b0; s2_sq <= '0; s2_a <= '0; s2_b <= '0;
    end else begin
      s1_v  <= start;
      s1_d  <= $signed({temp[TEMP_W-1], temp}) - T0_D;
      s1_a  <= coef_a;
      s1_b  <= coef_b;
      s2_v  <= s1_v && miss;
      s2_sq <= SQ_W'(s1_d * s1_d);
      s2_a  <= s1_a;
      s2_b  <= s1_b;
    end
  end

  always_comb begin
    a_ext  = P_W'(s2_a);
    sq_ext = P_W'({1'b0, s2_sq});
    prod   = a_ext * sq_ext;
    shr    = prod >>> A_FRAC;
    diff   = R_W'(s2_b) - R_W'(shr);
    if (!diff[R_W-1] && (|diff[R_W-2:ERR_W-1]))
      sat = {1'b0, {(ERR_W-1){1'b1}}};
    else if (diff[R_W-1] && !(&diff[R_W-2:ERR_W-1]))
      sat = {1'b1, {(ERR_W-1){1'b0}}};
    else
      sat = diff[ERR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      est_vld_q <= 1'b0;
      est_q     <= '0;
    end else begin
      est_vld_q <= s2_v;
      if (s2_v) est_q <= sat;
    end
  end
endmodule

// File: rtl/dc_tick.sv
module dc_tick #(
  parameter int PER_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period,
  output logic             fire
);
  logic [PER_W-1:0] cnt;

  assign fire = (period != '0) && (cnt >= period - PER_W'(1));

  always_ff @(posedge clk) begin
    if (rst || period == '0 || fire) cnt <= '0;
    else                             cnt <= cnt + PER_W'(1);
  end
endmodule

// File: rtl/drift_cache.sv
module drift_cache
  import dc_pkg::*;
#(
  parameter int TMIN   = -16,
  parameter int TMAX   = 63,
  parameter int T0     = 20,
  parameter int A_FRAC = 8,
  parameter int PER_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [7:0]       temp_i,
  input  logic                    upd_i,
  input  logic signed [15:0]      upd_err_i,
  input  logic                    clr_i,
  input  logic [PER_W-1:0]        period_i,
  input  logic signed [15:0]      coef_a_i,
  input  logic signed [15:0]      coef_b_i,
  output logic                    resp_valid_o,
  output logic                    hit_o,
  output logic                    resync_req_o,
  output logic signed [15:0]      cached_err_o,
  output logic                    est_valid_o,
  output logic signed [15:0]      est_o
);
  localparam int NBINS = TMAX - TMIN + 1;
  localparam int IDX_W = $clog2(NBINS);

  logic [IDX_W-1:0] idx;
  logic             in_range, fire, we, resp_q, hit_q;
  err_t             val_q;

  dc_bin_map #(.TMIN(TMIN), .NBINS(NBINS), .IDX_W(IDX_W)) u_map (
    .temp(temp_i), .idx(idx), .in_range(in_range)
  );

  dc_tick #(.PER_W(PER_W)) u_tick (
    .clk(clk), .rst(rst), .period(period_i), .fire(fire)
  );

  assign we = upd_i && in_range;

  dc_table #(.NBINS(NBINS), .IDX_W(IDX_W)) u_tab (
    .clk(clk), .rst(rst), .clr(clr_i), .we(we), .re(fire),
    .in_range(in_range), .idx(idx), .wdata(upd_err_i),
    .hit_q(hit_q), .val_q(val_q)
  );

  dc_quad #(.T0(T0), .A_FRAC(A_FRAC)) u_quad (
    .clk(clk), .rst(rst), .start(fire), .miss(!hit_q), .temp(temp_i),
    .coef_a(coef_a_i), .coef_b(coef_b_i),
    .est_vld_q(est_valid_o), .est_q(est_o)
  );

  always_ff @(posedge clk) begin
    if (rst) resp_q <= 1'b0;
    else     resp_q <= fire;
  end

  assign resp_valid_o = resp_q;
  assign hit_o        = hit_q;
  assign resync_req_o = resp_q && !hit_q;
  assign cached_err_o = hit_q ? val_q : '0;
endmodule

// File: rtl/drift_cache_chk.sv
module drift_cache_chk #(
  parameter int TMIN  = -16,
  parameter int TMAX  = 63,
  parameter int PER_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic signed [7:0] temp_i,
  input logic [PER_W-1:0]  period_i,
  input logic              resp_valid_o,
  input logic              hit_o,
  input logic              resync_req_o,
  input logic              est_valid_o
);
  // R3
  hit_no_est_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid_o && hit_o) |-> ##2 !est_valid_o);

  // R4
  miss_est_chk: assert property (@(posedge clk) disable iff (rst)
    resync_req_o |-> ##2 est_valid_o);

  // R4
  est_cause_chk: assert property (@(posedge clk) disable iff (rst)
    est_valid_o |-> $past(resync_req_o, 2));

  // R10
  period_gate_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid_o |-> ($past(period_i) != '0));

  // R7
  range_hit_chk: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (($past(temp_i) >= TMIN) && ($past(temp_i) <= TMAX)));
endmodule

bind drift_cache drift_cache_chk #(.TMIN(TMIN), .TMAX(TMAX), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst(rst), .temp_i(temp_i), .period_i(period_i),
  .resp_valid_o(resp_valid_o), .hit_o(hit_o),
  .resync_req_o(resync_req_o), .est_valid_o(est_valid_o)
);

// File: tb/drift_cache_bench.sv
module drift_cache_bench;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst;
  logic signed [7:0]  temp_i;
  logic               upd_i;
  logic signed [15:0] upd_err_i;
  logic               clr_i;
  logic [31:0]        period_i;
  logic signed [15:0] coef_a_i, coef_b_i;
  logic               resp_valid_o, hit_o, resync_req_o, est_valid_o;
  logic signed [15:0] cached_err_o, est_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drift_cache u_drift_cache (
    .clk(clk), .rst(rst), .temp_i(temp_i), .upd_i(upd_i), .upd_err_i(upd_err_i),
    .clr_i(clr_i), .period_i(period_i), .coef_a_i(coef_a_i), .coef_b_i(coef_b_i),
    .resp_valid_o(resp_valid_o), .hit_o(hit_o), .resync_req_o(resync_req_o),
    .cached_err_o(cached_err_o), .est_valid_o(est_valid_o), .est_o(est_o)
  );

  typedef struct packed {
    logic               is_chk;
    logic signed [7:0]  t;
    logic signed [15:0] v;
    logic               hit;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0,  8'sd25,  16'sd300,  1'b0},  // R2 write 25
    '{1'b1,  8'sd25,  16'sd300,  1'b1},  // R3 hit
    '{1'b1,  8'sd26,  16'sd0,    1'b0},  // R4 miss
    '{1'b0, -8'sd16, -16'sd500,  1'b0},  // R2 lowest slot
    '{1'b1, -8'sd16, -16'sd500,  1'b1},
    '{1'b0,  8'sd63,  16'sd1234, 1'b0},  // R2 highest slot
    '{1'b1,  8'sd63,  16'sd1234, 1'b1},
    '{1'b0,  8'sd64,  16'sd999,  1'b0},  // R7 above range ignored
    '{1'b1,  8'sd64,  16'sd0,    1'b0},
    '{1'b0, -8'sd17,  16'sd77,   1'b0},  // R7 below range ignored
    '{1'b1, -8'sd17,  16'sd0,    1'b0},
    '{1'b0,  8'sd25, -16'sd42,   1'b0},  // R11 overwrite
    '{1'b1,  8'sd25, -16'sd42,   1'b1},
    '{1'b1,  8'sd20,  16'sd0,    1'b0}   // R5 centre: estimate equals B
  };

  task automatic check_eq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint model(int t, longint a, longint b);
    longint d, p, r;
    d = t - 20;
    p = (a * d * d) >>> 8;
    r = b - p;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic do_update(int t, int v);
    @(negedge clk);
    temp_i = 8'(t); upd_i = 1'b1; upd_err_i = 16'(v);
    @(negedge clk);
    upd_i = 1'b0;
  endtask

  // issues one check, optionally with a write on the same cycle
  task automatic do_check(string req, int t, bit exp_hit, int exp_val, bit with_wr);
    @(negedge clk);
    temp_i = 8'(t); period_i = 32'd1;
    if (with_wr) begin upd_i = 1'b1; upd_err_i = 16'(exp_val); end
    @(negedge clk);
    period_i = 32'd0; upd_i = 1'b0;
    check_eq(req, "resp_valid", resp_valid_o, 1);
    check_eq(req, "hit", hit_o, exp_hit);
    check_eq(req, "resync_req", resync_req_o, !exp_hit);
    check_eq(req, "cached_err", cached_err_o, exp_hit ? exp_val : 0);
    @(negedge clk);
    check_eq(req, "est_valid early", est_valid_o, 0);
    @(negedge clk);
    check_eq(req, "est_valid", est_valid_o, !exp_hit);
    if (!exp_hit) check_eq(req, "est", est_o, model(t, coef_a_i, coef_b_i));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; temp_i = '0; upd_i = 1'b0; upd_err_i = '0; clr_i = 1'b0;
    period_i = '0; coef_a_i = 16'sd64; coef_b_i = 16'sd150;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_eq("R1", "resp_valid", resp_valid_o, 0);
    check_eq("R1", "hit", hit_o, 0);
    check_eq("R1", "resync_req", resync_req_o, 0);
    check_eq("R1", "cached_err", cached_err_o, 0);
    check_eq("R1", "est_valid", est_valid_o, 0);
    check_eq("R1", "est", est_o, 0);
    do_check("R1", 30, 1'b0, 0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_chk)
        do_check(VEC[i].hit ? "R3" : "R4", int'(VEC[i].t), VEC[i].hit, int'(VEC[i].v), 1'b0);
      else
        do_update(int'(VEC[i].t), int'(VEC[i].v));
    end

    // R5 floor rounding of a negative product: -3>>>8 = -1, so 150+1
    coef_a_i = -16'sd3;
    do_check("R5", 21, 1'b0, 0, 1'b0);
    coef_a_i = 16'sd64;
    do_check("R5", -10, 1'b0, 0, 1'b0);

    // R6 saturation both ways
    coef_a_i = -16'sd32768; coef_b_i = 16'sd0;
    do_check("R6", -128, 1'b0, 0, 1'b0);
    check_eq("R6", "est high clamp", est_o, 32767);
    coef_a_i = 16'sd32767; coef_b_i = -16'sd32768;
    do_check("R6", 100, 1'b0, 0, 1'b0);
    check_eq("R6", "est low clamp", est_o, -32768);
    coef_a_i = 16'sd64; coef_b_i = 16'sd150;

    // R9 same-cycle write and lookup
    do_check("R9", 40, 1'b1, 321, 1'b1);

    // R8 clear, then clear together with a write
    do_update(30, 55);
    do_check("R8", 30, 1'b1, 55, 1'b0);
    @(negedge clk) clr_i = 1'b1;
    @(negedge clk) clr_i = 1'b0;
    do_check("R8", 30, 1'b0, 0, 1'b0);
    do_check("R8", 25, 1'b0, 0, 1'b0);
    do_check("R8", 40, 1'b0, 0, 1'b0);
    @(negedge clk);
    temp_i = 8'sd31; clr_i = 1'b1; upd_i = 1'b1; upd_err_i = 16'sd66;
    @(negedge clk) begin clr_i = 1'b0; upd_i = 1'b0; end
    do_check("R8", 31, 1'b1, 66, 1'b0);

    // R10 periodic checks every 5 cycles, then disabled
    begin
      int n;
      @(negedge clk) period_i = 32'd5;
      n = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk); n++;
        if (resp_valid_o) break;
      end
      check_eq("R10", "first interval", n, 5);
      n = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk); n++;
        if (resp_valid_o) break;
      end
      check_eq("R10", "second interval", n, 5);
      period_i = 32'd0;
      n = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (resp_valid_o) n++;
      end
      check_eq("R10", "responses while disabled", n, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule